// File: doc/BRIEF.md
# I/O Window Address Decoder with Wait States

This block turns a 16-bit processor bus address into chip selects for a 48KB RAM, an 8KB ROM and a set of peripheral ranges packed into an 8KB I/O window. The window is split into ranges that halve in size: 4KB, 2KB, 1KB, 512B and 256B. Each range is recognised by a run of ones followed by a zero in the address bits just under the window prefix. The topmost 256 bytes of the window are held back and never selected. Every select is purely combinational from the address. Separate read and write strobes are also produced, gated by the bus phase qualifier and by the read/write line, so that write-only latches cannot load during a read.

Slow or heavily loaded regions get wait states. A bus access is offered with `req_valid` for one cycle on the first cycle of a new address. `req_ready` goes low in that same cycle when the region needs stretching, and stays low for exactly the region's stretch count. While `req_ready` is low the requester must hold the address, `rw` and the configuration inputs stable and keep `req_valid` low. The access completes on the first cycle with `req_ready` high. A region with no stretch is accepted in the cycle it is offered. The stretch counter is reloaded from every new offer.

Top module: `io_window_decoder`

## Requirements
- R1: Addresses 0x0000-0xBFFF assert `ram_cs` and are accepted with zero wait cycles.
- R2: Addresses 0xE000-0xFFFF assert `rom_cs` and are stretched by 2 cycles when `cfg_rom_slow`=0 and by 4 cycles when `cfg_rom_slow`=1.
- R3: Addresses 0xC000-0xCFFF assert `van_cs[i]` only, with i = addr[11:10], and have no stretch.
- R4: Addresses 0xD000-0xDBFF and 0xDF00-0xDFFF assert no chip select, no control select and no control write strobe, and have no stretch.
- R5: Addresses 0xDC00-0xDDFF assert `ctl_sel[i]` with i = addr[8:7] for i = 0, 1, 2 (0 privilege control, 1 shift register, 2 video register). Index 3 asserts nothing. All accesses in the range are stretched by 1 cycle.
- R6: `ctl_wstb[i]` is high exactly when `ctl_sel[i]`, `phi2`=1 and `rw`=0 (write). It is never high during a read.
- R7: With `cfg_serial`=0, addresses 0xDE00-0xDEFF assert `per_cs[s]` for slot s = addr[7:4] when s is 0 to 4 (slot 0 is the privileged peripheral). Other slots and `per_cs[5]` stay low. There is no stretch.
- R8: With `cfg_serial`=1, addresses 0xDE00-0xDEFF assert `per_cs[s]` for s = addr[7:4] when s is 0 to 5. Other slots assert nothing.
- R9: `rd_stb` = `phi2` AND `rw`, and `wr_stb` = `phi2` AND NOT `rw`, for every address.
- R10: For any address, at most one of `ram_cs`, `rom_cs`, `van_cs`, `ctl_sel` and `per_cs` is high.
- R11: `req_ready` is high out of reset and while idle. An offer to a region with stretch N drives `req_ready` low for exactly N consecutive cycles starting in the offer cycle, then high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Bus address |
| rw | input | 1 | 1 = read, 0 = write |
| phi2 | input | 1 | Bus phase qualifier, high during the data phase |
| req_valid | input | 1 | High for one cycle on the first cycle of a new address |
| cfg_rom_slow | input | 1 | ROM stretch select: 0 = 2 cycles, 1 = 4 cycles |
| cfg_serial | input | 1 | Peripheral range layout: 0 = 1 privileged + 4 plain, 1 = six serial |
| req_ready | output | 1 | Low while the current access is being stretched |
| ram_cs | output | 1 | RAM select |
| rom_cs | output | 1 | ROM select |
| van_cs | output | 4 | Video/audio/network selects in the 4KB range |
| ctl_sel | output | 3 | Unqualified control-range selects |
| ctl_wstb | output | 3 | Control-range write strobes, phase and write qualified |
| per_cs | output | 6 | Peripheral slot selects in the 256B range |
| rd_stb | output | 1 | Phase-qualified read strobe |
| wr_stb | output | 1 | Phase-qualified write strobe |

## Verification
Address decode and the wait-state stall fall in the same cycle: a ROM or control-range offer must show its chip select and drop `req_ready` in the very cycle `req_valid` is high. The scoreboard compares the full select vector in that cycle. It then counts the low-ready cycles that start there and compares the count with the stretch the address and `cfg_rom_slow` call for. This is done across a sweep of all 65536 addresses and again with the slow ROM setting and the serial layout.

// File: rtl/iowd_pkg.sv
package iowd_pkg;

  typedef enum logic [2:0] {
    RG_RAM,
    RG_ROM,
    RG_VAN,
    RG_RSV2K,
    RG_RSV1K,
    RG_CTL,
    RG_PER,
    RG_RSVTOP
  } region_e;

  localparam int SUB_W = 4;

endpackage

// File: rtl/iowd_region.sv
module iowd_region
  import iowd_pkg::*;
(
  input  logic [15:4]      addr_hi,
  output region_e          region,
  output logic [SUB_W-1:0] sub
);

  localparam int NEST_N = 5;

  logic       in_window;
  logic [2:0] zero_pos;
  logic       zero_found;

  assign in_window = (addr_hi[15:13] == 3'b110);

  // Position of the first zero below the window prefix picks the nested range.
  always_comb begin
    zero_found = 1'b0;
    zero_pos   = 3'(NEST_N);
    for (int k = 0; k < NEST_N; k++) begin
      if (!zero_found && !addr_hi[12-k]) begin
        zero_pos   = 3'(k);
        zero_found = 1'b1;
      end
    end
  end

  always_comb begin
    region = RG_RAM;
    sub    = '0;
    if (addr_hi[15:13] == 3'b111) begin
      region = RG_ROM;
    end else if (in_window) begin
      case (zero_pos)
        3'd0: begin
          region = RG_VAN;
          sub    = {2'b00, addr_hi[11:10]};
        end
        3'd1: region = RG_RSV2K;
        3'd2: region = RG_RSV1K;
        3'd3: begin
          region = RG_CTL;
          sub    = {2'b00, addr_hi[8:7]};
        end
        3'd4: begin
          region = RG_PER;
          sub    = addr_hi[7:4];
        end
        default: region = RG_RSVTOP;
      endcase
    end
  end

endmodule

// File: rtl/iowd_select.sv
module iowd_select
  import iowd_pkg::*;
#(
  parameter int VAN_N     = 4,
  parameter int CTL_N     = 3,
  parameter int PER_N     = 6,
  parameter int PER_STD_N = 5
) (
  input  region_e          region,
  input  logic [SUB_W-1:0] sub,
  input  logic             cfg_serial,
  input  logic             phi2,
  input  logic             rw,
  output logic             ram_cs,
  output logic             rom_cs,
  output logic [VAN_N-1:0] van_cs,
  output logic [CTL_N-1:0] ctl_sel,
  output logic [CTL_N-1:0] ctl_wstb,
  output logic [PER_N-1:0] per_cs,
  output logic             rd_stb,
  output logic             wr_stb
);

  logic hit_van, hit_ctl, hit_per, wr_phase;

  assign ram_cs   = (region == RG_RAM);
  assign rom_cs   = (region == RG_ROM);
  assign hit_van  = (region == RG_VAN);
  assign hit_ctl  = (region == RG_CTL);
  assign hit_per  = (region == RG_PER);
  assign rd_stb   = phi2 & rw;
  assign wr_stb   = phi2 & ~rw;
  assign wr_phase = wr_stb;

  for (genvar i = 0; i < VAN_N; i++) begin : g_van
    assign van_cs[i] = hit_van && (sub == SUB_W'(i));
  end

  for (genvar i = 0; i < CTL_N; i++) begin : g_ctl
    assign ctl_sel[i]  = hit_ctl && (sub == SUB_W'(i));
    assign ctl_wstb[i] = ctl_sel[i] && wr_phase;
  end

  for (genvar i = 0; i < PER_N; i++) begin : g_per
    if (i < PER_STD_N) begin : g_both
      assign per_cs[i] = hit_per && (sub == SUB_W'(i));
    end else begin : g_serial_only
      assign per_cs[i] = hit_per && cfg_serial && (sub == SUB_W'(i));
    end
  end

endmodule

// File: rtl/iowd_wait.sv
module iowd_wait
  import iowd_pkg::*;
#(
  parameter int CTL_STRETCH = 1,
  parameter int ROM_FAST    = 2,
  parameter int ROM_SLOW    = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  region_e region,
  input  logic    cfg_rom_slow,
  output logic    req_ready
);

  localparam int CNT_W = $clog2(ROM_SLOW + 1);

  logic [CNT_W-1:0] stretch, cnt_q, cnt_d;

  always_comb begin
    case (region)
      RG_CTL:  stretch = CNT_W'(CTL_STRETCH);
      RG_ROM:  stretch = cfg_rom_slow ? CNT_W'(ROM_SLOW) : CNT_W'(ROM_FAST);
      default: stretch = '0;
    endcase
  end

  always_comb begin
    if (req_valid) begin
      req_ready = (stretch == '0);
      cnt_d     = (stretch == '0) ? '0 : stretch - CNT_W'(1);
    end else begin
      req_ready = (cnt_q == '0);
      cnt_d     = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
  import iowd_pkg::*;
#(
  parameter int VAN_N       = 4,
  parameter int CTL_N       = 3,
  parameter int PER_N       = 6,
  parameter int PER_STD_N   = 5,
  parameter int CTL_STRETCH = 1,
  parameter int ROM_FAST    = 2,
  parameter int ROM_SLOW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      addr,
  input  logic             rw,
  input  logic             phi2,
  input  logic             req_valid,
  input  logic             cfg_rom_slow,
  input  logic             cfg_serial,
  output logic             req_ready,
  output logic             ram_cs,
  output logic             rom_cs,
  output logic [VAN_N-1:0] van_cs,
  output logic [CTL_N-1:0] ctl_sel,
  output logic [CTL_N-1:0] ctl_wstb,
  output logic [PER_N-1:0] per_cs,
  output logic             rd_stb,
  output logic             wr_stb
);

  region_e          region;
  logic [SUB_W-1:0] sub;
  logic             unused_lo;

  assign unused_lo = ^addr[3:0];

  iowd_region u_region (
    .addr_hi (addr[15:4]),
    .region  (region),
    .sub     (sub)
  );

  iowd_select #(
    .VAN_N     (VAN_N),
    .CTL_N     (CTL_N),
    .PER_N     (PER_N),
    .PER_STD_N (PER_STD_N)
  ) u_select (
    .region     (region),
    .sub        (sub),
    .cfg_serial (cfg_serial),
    .phi2       (phi2),
    .rw         (rw),
    .ram_cs     (ram_cs),
    .rom_cs     (rom_cs),
    .van_cs     (van_cs),
    .ctl_sel    (ctl_sel),
    .ctl_wstb   (ctl_wstb),
    .per_cs     (per_cs),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb)
  );

  iowd_wait #(
    .CTL_STRETCH (CTL_STRETCH),
    .ROM_FAST    (ROM_FAST),
    .ROM_SLOW    (ROM_SLOW)
  ) u_wait (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .region       (region),
    .cfg_rom_slow (cfg_rom_slow),
    .req_ready    (req_ready)
  );

endmodule

// File: rtl/iowd_checker.sv
module iowd_checker #(
  parameter int VAN_N = 4,
  parameter int CTL_N = 3,
  parameter int PER_N = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [15:0]      addr,
  input logic             rw,
  input logic             phi2,
  input logic             req_valid,
  input logic             cfg_rom_slow,
  input logic             req_ready,
  input logic             ram_cs,
  input logic             rom_cs,
  input logic [VAN_N-1:0] van_cs,
  input logic [CTL_N-1:0] ctl_sel,
  input logic [CTL_N-1:0] ctl_wstb,
  input logic [PER_N-1:0] per_cs,
  input logic             rd_stb,
  input logic             wr_stb
);

  logic [VAN_N+CTL_N+PER_N+1:0] all_sel;
  assign all_sel = {per_cs, ctl_sel, van_cs, rom_cs, ram_cs};

  p_one_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(all_sel));

  p_top_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[15:8] == 8'hDF) |-> (all_sel == '0) && (ctl_wstb == '0));

  p_ctl_wstb_qual_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wstb != '0) |-> (phi2 && !rw));

  p_rd_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> (phi2 && rw && !wr_stb));

  p_wr_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (phi2 && !rw));

  p_ram_nostall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ram_cs) |-> req_ready);

  p_rom_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rom_cs) |-> !req_ready);

  p_rom_fast_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && $past(!req_valid) && $past(req_valid && rom_cs && !cfg_rom_slow, 2))
      |-> req_ready);

  p_ctl_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && $past(req_valid && (addr[15:9] == 7'b1101110))) |-> req_ready);

endmodule

bind io_window_decoder iowd_checker #(
  .VAN_N (VAN_N),
  .CTL_N (CTL_N),
  .PER_N (PER_N)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr         (addr),
  .rw           (rw),
  .phi2         (phi2),
  .req_valid    (req_valid),
  .cfg_rom_slow (cfg_rom_slow),
  .req_ready    (req_ready),
  .ram_cs       (ram_cs),
  .rom_cs       (rom_cs),
  .van_cs       (van_cs),
  .ctl_sel      (ctl_sel),
  .ctl_wstb     (ctl_wstb),
  .per_cs       (per_cs),
  .rd_stb       (rd_stb),
  .wr_stb       (wr_stb)
);

// File: tb/sim_io_window_decoder.sv
module sim_io_window_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        rw = 1'b1;
  logic        phi2 = 1'b0;
  logic        req_valid = 1'b0;
  logic        cfg_rom_slow = 1'b0;
  logic        cfg_serial = 1'b0;
  logic        req_ready, ram_cs, rom_cs, rd_stb, wr_stb;
  logic [3:0]  van_cs;
  logic [2:0]  ctl_sel, ctl_wstb;
  logic [5:0]  per_cs;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_window_decoder u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rw(rw), .phi2(phi2),
    .req_valid(req_valid), .cfg_rom_slow(cfg_rom_slow), .cfg_serial(cfg_serial),
    .req_ready(req_ready), .ram_cs(ram_cs), .rom_cs(rom_cs), .van_cs(van_cs),
    .ctl_sel(ctl_sel), .ctl_wstb(ctl_wstb), .per_cs(per_cs),
    .rd_stb(rd_stb), .wr_stb(wr_stb)
  );

  typedef struct {
    logic [15:0] a;
    logic [14:0] sel;
    int          st;
  } exp_t;

  exp_t sb[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference model: {per[5:0], ctl[2:0], van[3:0], rom, ram}
  function automatic logic [14:0] exp_sel(input logic [15:0] a, input logic serial);
    logic [14:0] s = '0;
    int slot;
    if (a < 16'hC000) s[0] = 1'b1;
    else if (a >= 16'hE000) s[1] = 1'b1;
    else if (a < 16'hD000) s[2 + a[11:10]] = 1'b1;
    else if (a >= 16'hDC00 && a < 16'hDE00) begin
      if (a[8:7] != 2'd3) s[6 + a[8:7]] = 1'b1;
    end else if (a >= 16'hDE00 && a < 16'hDF00) begin
      slot = int'(a[7:4]);
      if (slot < (serial ? 6 : 5)) s[9 + slot] = 1'b1;
    end
    return s;
  endfunction

  function automatic int exp_st(input logic [15:0] a, input logic slow);
    if (a >= 16'hE000) return slow ? 4 : 2;
    if (a >= 16'hDC00 && a < 16'hDE00) return 1;
    return 0;
  endfunction

  function automatic string tag_of(input logic [15:0] a, input logic serial);
    if (a < 16'hC000) return "R1";
    if (a >= 16'hE000) return "R2";
    if (a < 16'hD000) return "R3";
    if (a < 16'hDC00 || a >= 16'hDF00) return "R4";
    if (a < 16'hDE00) return "R5";
    return serial ? "R8" : "R7";
  endfunction

  // Driver: pushes the expected item, then offers the access and holds it.
  task automatic issue(input logic [15:0] a, input logic r);
    exp_t e;
    e.a = a;
    e.sel = exp_sel(a, cfg_serial);
    e.st = exp_st(a, cfg_rom_slow);
    sb.push_back(e);
    @(posedge clk); #1;
    addr = a; rw = r; req_valid = 1'b1;
    @(negedge clk);
    if (!req_ready) begin
      @(posedge clk); #1;
      req_valid = 1'b0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares selects in the offer cycle, then counts stall cycles.
  exp_t cur;
  bit   busy = 1'b0;
  int   run = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (req_valid) begin
        if (sb.size() == 0) begin
          check("R11", 32'd1, 32'd0, "offer with empty scoreboard");
        end else begin
          cur = sb.pop_front();
          check(tag_of(cur.a, cfg_serial), {17'd0, per_cs, ctl_sel, van_cs, rom_cs, ram_cs},
                {17'd0, cur.sel}, $sformatf("selects @%04h", cur.a));
          if (req_ready) check("R11", 32'd0, 32'(cur.st), $sformatf("stall @%04h", cur.a));
          else begin busy = 1'b1; run = 1; end
        end
      end else if (busy) begin
        if (!req_ready) run++;
        else begin
          busy = 1'b0;
          check("R11", 32'(run), 32'(cur.st), $sformatf("stall @%04h", cur.a));
        end
      end
    end
  end

  task automatic strobe_case(input logic [15:0] a, input logic r, input logic p);
    logic [2:0] ce;
    @(posedge clk); #1;
    addr = a; rw = r; phi2 = p; req_valid = 1'b0;
    @(negedge clk);
    check("R9", {31'd0, rd_stb}, {31'd0, p & r}, $sformatf("rd_stb @%04h", a));
    check("R9", {31'd0, wr_stb}, {31'd0, p & ~r}, $sformatf("wr_stb @%04h", a));
    ce = '0;
    if (a >= 16'hDC00 && a < 16'hDE00 && a[8:7] != 2'd3 && p && !r) ce[a[8:7]] = 1'b1;
    check("R6", {29'd0, ctl_wstb}, {29'd0, ce}, $sformatf("ctl_wstb @%04h", a));
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11", {31'd0, req_ready}, 32'd1, "ready during reset");
    check("R9", {30'd0, rd_stb, wr_stb}, 32'd0, "strobes low in reset with phi2 low");
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", {31'd0, req_ready}, 32'd1, "ready idle after reset");

    // Full sweep of every address, R1-type layout and fast ROM.
    for (int a = 0; a < 65536; a++) issue(16'(a), 1'b1);
    idle(2);

    // Slow ROM stretch (R2) including the range edges.
    cfg_rom_slow = 1'b1;
    issue(16'hE000, 1'b1);
    issue(16'hDFFF, 1'b1);
    issue(16'hFFFF, 1'b0);
    issue(16'hBFFF, 1'b0);
    issue(16'hF123, 1'b1);
    cfg_rom_slow = 1'b0;
    issue(16'hE001, 1'b1);

    // Serial layout of the peripheral range (R8).
    idle(1);
    cfg_serial = 1'b1;
    for (int a = 16'hDE00; a < 16'hDF00; a += 8) issue(16'(a), 1'b1);
    issue(16'hDF00, 1'b1);
    idle(1);
    cfg_serial = 1'b0;
    issue(16'hDE50, 1'b1);
    idle(2);

    // Strobe qualification (R6, R9).
    strobe_case(16'hDC00, 1'b0, 1'b1);
    strobe_case(16'hDC00, 1'b1, 1'b1);
    strobe_case(16'hDC80, 1'b0, 1'b0);
    strobe_case(16'hDD00, 1'b0, 1'b1);
    strobe_case(16'hDD80, 1'b0, 1'b1);
    strobe_case(16'hDF00, 1'b0, 1'b1);
    strobe_case(16'h1234, 1'b1, 1'b1);
    strobe_case(16'h1234, 1'b0, 1'b0);
    strobe_case(16'hC400, 1'b0, 1'b1);

    idle(2);
    check("R11", 32'(sb.size()), 32'd0, "scoreboard drained");
    check("R11", {31'd0, req_ready}, 32'd1, "ready idle at end");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule